// File: doc/BRIEF.md
# Depth-wise streaming cross-correlation engine

This block correlates a search feature map with a small square kernel, one channel at a time. Each channel has its own K×K kernel. For every channel the block first takes the kernel coefficients from a coefficient stream. It then takes that channel's search pixels in raster order from a pixel stream, keeps the previous K−1 rows in line buffers, and slides a K×K window register across the image. For each window position on the stride grid it emits one multiply-accumulate result on a valid/ready output stream. No sum is taken across channels. The results are concatenated in channel order.

A controller pulses `start` with the height, width, stride and channel count on the configuration inputs. The block checks these values before it does any work. If they are illegal, it reports an error and finishes at once. Otherwise it runs every channel and pulses `done` after the last result has been taken.

Top module: `dwxc_engine`

## Requirements
- R1: A configuration is illegal when stride is 0, height < K, width < K, width > MAX_W (the line-buffer capacity), or the channel count is 0. On an illegal `start`, `cfg_err` and a one-cycle `done` appear in the cycle after `start`. No coefficient, pixel or result is exchanged, and `cfg_err` stays high until the next legal `start`.
- R2: For each channel, exactly K·K coefficients are accepted, in raster order: coefficient index r·K+c holds kernel row r, column c. `pix_ready` stays low until all of them have been taken.
- R3: The kernel is not flipped. For output (i,j), `out_data` = Σ over r,c of coef[r][c]·pix[i·S+r][j·S+c].
- R4: Channel n is correlated only with the n-th kernel. The results of channel 0 come first, then those of channel 1, and so on.
- R5: Each channel yields floor((H−K)/S)+1 rows by floor((W−K)/S)+1 columns of results, in row-major order. Only complete windows are used.
- R6: Pixels and coefficients are signed 8-bit values. `out_data` is a 2·8+ceil(log2(K·K))-bit signed sum that is not saturated. With K=3 and every value equal to −128, the result is 147456.
- R7: `out_last` is high on the final result of each channel and on no other result.
- R8: `done` is a one-cycle pulse. It follows the acceptance of the last result of the last channel, and `out_valid` is low while it is high.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values and `pix_ready` is low, so no result is lost.
- R10: After reset, `out_valid`, `coef_ready`, `pix_ready`, `done` and `cfg_err` are all low.
- R11: `coef_ready` and `pix_ready` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a job with the configuration inputs |
| cfg_height | input | DIM_W | Search map height H |
| cfg_width | input | DIM_W | Search map width W |
| cfg_stride | input | SW | Stride S |
| cfg_chans | input | CHW | Number of channels |
| coef_valid | input | 1 | Coefficient stream valid |
| coef_ready | output | 1 | Coefficient stream ready |
| coef_data | input | DW | Signed kernel coefficient |
| pix_valid | input | 1 | Pixel stream valid |
| pix_ready | output | 1 | Pixel stream ready |
| pix_data | input | DW | Signed search pixel |
| out_valid | output | 1 | Result stream valid |
| out_ready | input | 1 | Result stream ready |
| out_data | output | 2·DW+ceil(log2(K·K)) | Signed correlation sum |
| out_last | output | 1 | Final result of the current channel |
| done | output | 1 | Job finished (one-cycle pulse) |
| cfg_err | output | 1 | Last start had an illegal configuration |

## Verification
The bench covers several corner cases, and each one shows up differently in a faulty design:

- **Stride larger than the remaining span.** The stride-2 case has trailing columns that produce no result. The stride-5 case yields a single result per channel. A faulty grid would emit extra results or wrong sums.
- **Full line-buffer width.** A width equal to MAX_W would expose an off-by-one in the buffer index.
- **Channel-to-kernel pairing.** Several channels run with different kernels. A design that kept an old kernel would produce sums that differ from the second channel on.
- **Accumulator width.** An all-−128 job checks for sign or width errors, which would show as a wrapped sum.
- **Illegal configurations.** Each illegal case must finish at once with no traffic.
- **Backpressure.** Results are taken under backpressure. A design that dropped or changed a held result would fail the data or count checks.

// File: rtl/dwxc_pkg.sv
package dwxc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_LOAD   = 2'd1,
      ST_STREAM = 2'd2,
      ST_DRAIN  = 2'd3
   } dwxc_state_t;

   function automatic int acc_width(input int dw, input int k);
      return 2 * dw + $clog2(k * k);
   endfunction
endpackage

// File: rtl/dwxc_cfg_check.sv
module dwxc_cfg_check #(
   parameter int K     = 3,
   parameter int MAX_W = 16,
   parameter int DIM_W = 8,
   parameter int SW    = 4,
   parameter int CHW   = 4
) (
   input  logic [DIM_W-1:0] height,
   input  logic [DIM_W-1:0] width,
   input  logic [SW-1:0]    stride,
   input  logic [CHW-1:0]   chans,
   output logic             legal
);
   always_comb begin
      legal = (stride != '0) && (chans != '0)
           && (32'(height) >= K) && (32'(width) >= K)
           && (32'(width) <= MAX_W);
   end
endmodule

// File: rtl/dwxc_coef_store.sv
module dwxc_coef_store #(
   parameter int DW = 8,
   parameter int K  = 3,
   localparam int NK = K * K,
   localparam int IW = $clog2(NK + 1)
) (
   input  logic                    clk,
   input  logic                    we,
   input  logic [IW-1:0]           idx,
   input  logic [DW-1:0]           din,
   output logic [NK-1:0][DW-1:0]   coefs
);
   logic [NK-1:0][DW-1:0] mem;

   always_ff @(posedge clk) begin
      if (we) mem[idx] <= din;
   end

   assign coefs = mem;
endmodule

// File: rtl/dwxc_window.sv
module dwxc_window #(
   parameter int DW    = 8,
   parameter int K     = 3,
   parameter int MAX_W = 16,
   localparam int CW   = (MAX_W > 1) ? $clog2(MAX_W) : 1,
   localparam int NK   = K * K
) (
   input  logic                  clk,
   input  logic                  shift,
   input  logic [CW-1:0]         col,
   input  logic [DW-1:0]         pix,
   output logic [NK-1:0][DW-1:0] win_flat
);
   logic [K-1:0][DW-1:0]          col_v;
   logic [K-1:0][K-1:0][DW-1:0]   win;

   if (K > 1) begin : g_lbuf
      // lb[0] holds the oldest stored row, lb[K-2] the newest
      logic [K-2:0][MAX_W-1:0][DW-1:0] lb;
      always_comb begin
         for (int k = 0; k < K - 1; k++) col_v[k] = lb[k][col];
         col_v[K-1] = pix;
      end
      always_ff @(posedge clk) begin
         if (shift) begin
            for (int k = 0; k < K - 2; k++) lb[k][col] <= lb[k+1][col];
            lb[K-2][col] <= pix;
         end
      end
   end else begin : g_nolbuf
      assign col_v[0] = pix;
   end

   always_ff @(posedge clk) begin
      if (shift) begin
         for (int r = 0; r < K; r++) begin
            for (int j = 0; j < K - 1; j++) win[r][j] <= win[r][j+1];
            win[r][K-1] <= col_v[r];
         end
      end
   end

   always_comb begin
      for (int r = 0; r < K; r++)
         for (int j = 0; j < K; j++)
            win_flat[r*K+j] = win[r][j];
   end
endmodule

// File: rtl/dwxc_mac.sv
module dwxc_mac #(
   parameter int DW    = 8,
   parameter int K     = 3,
   localparam int NK   = K * K,
   localparam int ACC_W = dwxc_pkg::acc_width(DW, K)
) (
   input  logic [NK-1:0][DW-1:0] win,
   input  logic [NK-1:0][DW-1:0] coefs,
   output logic [ACC_W-1:0]      acc
);
   logic signed [2*DW-1:0] prod [NK];
   logic signed [ACC_W-1:0] sum;

   for (genvar i = 0; i < NK; i++) begin : g_prod
      assign prod[i] = $signed(win[i]) * $signed(coefs[i]);
   end

   always_comb begin
      sum = '0;
      for (int i = 0; i < NK; i++) sum = sum + ACC_W'(prod[i]);
   end

   assign acc = sum;
endmodule

// File: rtl/dwxc_engine.sv
module dwxc_engine
   import dwxc_pkg::*;
#(
   parameter int DW    = 8,
   parameter int K     = 3,
   parameter int MAX_W = 16,
   parameter int DIM_W = 8,
   parameter int SW    = 4,
   parameter int CHW   = 4
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                start,
   input  logic [DIM_W-1:0]                    cfg_height,
   input  logic [DIM_W-1:0]                    cfg_width,
   input  logic [SW-1:0]                       cfg_stride,
   input  logic [CHW-1:0]                      cfg_chans,
   input  logic                                coef_valid,
   output logic                                coef_ready,
   input  logic [DW-1:0]                       coef_data,
   input  logic                                pix_valid,
   output logic                                pix_ready,
   input  logic [DW-1:0]                       pix_data,
   output logic                                out_valid,
   input  logic                                out_ready,
   output logic [2*DW+$clog2(K*K)-1:0]         out_data,
   output logic                                out_last,
   output logic                                done,
   output logic                                cfg_err
);
   localparam int NK    = K * K;
   localparam int IW    = $clog2(NK + 1);
   localparam int CW    = (MAX_W > 1) ? $clog2(MAX_W) : 1;
   localparam int ACC_W = acc_width(DW, K);

   if (K < 1) begin : g_bad_k
      $error("dwxc_engine: K must be at least 1");
   end
   if (MAX_W < K) begin : g_bad_maxw
      $error("dwxc_engine: MAX_W must be at least K");
   end
   if (DIM_W < CW || (1 << DIM_W) <= MAX_W) begin : g_bad_dim
      $error("dwxc_engine: DIM_W too narrow for MAX_W");
   end

   dwxc_state_t       st;
   logic [DIM_W-1:0]  h_q, w_q, row, col;
   logic [SW-1:0]     s_q, rph, cph;
   logic [CHW-1:0]    ch_q, ch_idx;
   logic [IW-1:0]     cidx;
   logic              win_vld, win_last, done_q, err_q;
   logic              legal;

   logic [NK-1:0][DW-1:0] coefs, win;
   logic [ACC_W-1:0]      acc;

   dwxc_cfg_check #(.K(K), .MAX_W(MAX_W), .DIM_W(DIM_W), .SW(SW), .CHW(CHW)) u_cfg (
      .height(cfg_height), .width(cfg_width), .stride(cfg_stride),
      .chans(cfg_chans), .legal(legal)
   );

   logic coef_take, pix_take, out_take;
   assign coef_ready = (st == ST_LOAD);
   assign coef_take  = coef_valid && coef_ready;
   assign pix_ready  = (st == ST_STREAM) && (!win_vld || out_ready);
   assign pix_take   = pix_valid && pix_ready;
   assign out_take   = win_vld && out_ready;

   dwxc_coef_store #(.DW(DW), .K(K)) u_coef (
      .clk(clk), .we(coef_take), .idx(cidx), .din(coef_data), .coefs(coefs)
   );

   dwxc_window #(.DW(DW), .K(K), .MAX_W(MAX_W)) u_win (
      .clk(clk), .shift(pix_take), .col(col[CW-1:0]), .pix(pix_data), .win_flat(win)
   );

   dwxc_mac #(.DW(DW), .K(K)) u_mac (.win(win), .coefs(coefs), .acc(acc));

   // window position of the current pixel and its place on the stride grid
   logic row_full, col_full, fire, last_pos, end_row, end_ch;
   assign row_full = (32'(row) >= K - 1);
   assign col_full = (32'(col) >= K - 1);
   assign fire     = row_full && col_full && (rph == '0) && (cph == '0);
   assign last_pos = ({1'b0, row} + (DIM_W+1)'(s_q) >= {1'b0, h_q})
                  && ({1'b0, col} + (DIM_W+1)'(s_q) >= {1'b0, w_q});
   assign end_row  = (col == w_q - 1'b1);
   assign end_ch   = end_row && (row == h_q - 1'b1);

   function automatic logic [SW-1:0] next_ph(input logic full, input logic [SW-1:0] ph,
                                             input logic [SW-1:0] s);
      if (!full)             return '0;
      else if (ph == s - 1'b1) return '0;
      else                   return ph + 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         h_q      <= '0;
         w_q      <= '0;
         s_q      <= '0;
         ch_q     <= '0;
         ch_idx   <= '0;
         cidx     <= '0;
         row      <= '0;
         col      <= '0;
         rph      <= '0;
         cph      <= '0;
         win_vld  <= 1'b0;
         win_last <= 1'b0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;

         if (pix_take) begin
            win_vld  <= fire;
            win_last <= fire && last_pos;
         end else if (out_take) begin
            win_vld  <= 1'b0;
            win_last <= 1'b0;
         end

         unique case (st)
            ST_IDLE: if (start) begin
               h_q  <= cfg_height;
               w_q  <= cfg_width;
               s_q  <= cfg_stride;
               ch_q <= cfg_chans;
               if (!legal) begin
                  err_q  <= 1'b1;
                  done_q <= 1'b1;
               end else begin
                  err_q  <= 1'b0;
                  ch_idx <= '0;
                  cidx   <= '0;
                  st     <= ST_LOAD;
               end
            end
            ST_LOAD: if (coef_take) begin
               cidx <= cidx + 1'b1;
               if (32'(cidx) == NK - 1) begin
                  row <= '0;
                  col <= '0;
                  rph <= '0;
                  cph <= '0;
                  st  <= ST_STREAM;
               end
            end
            ST_STREAM: if (pix_take) begin
               if (end_row) begin
                  col <= '0;
                  cph <= '0;
                  row <= row + 1'b1;
                  rph <= next_ph(row_full, rph, s_q);
               end else begin
                  col <= col + 1'b1;
                  cph <= next_ph(col_full, cph, s_q);
               end
               if (end_ch) st <= ST_DRAIN;
            end
            ST_DRAIN: if (!win_vld || out_ready) begin
               if (ch_idx == ch_q - 1'b1) begin
                  done_q <= 1'b1;
                  st     <= ST_IDLE;
               end else begin
                  ch_idx <= ch_idx + 1'b1;
                  cidx   <= '0;
                  st     <= ST_LOAD;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign out_valid = win_vld;
   assign out_data  = acc;
   assign out_last  = win_last;
   assign done      = done_q;
   assign cfg_err   = err_q;
endmodule

// File: rtl/dwxc_engine_chk.sv
module dwxc_engine_chk #(
   parameter int DW    = 8,
   parameter int K     = 3,
   parameter int MAX_W = 16,
   parameter int DIM_W = 8,
   parameter int SW    = 4,
   parameter int CHW   = 4
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        coef_ready,
   input logic                        pix_ready,
   input logic                        out_valid,
   input logic                        out_ready,
   input logic [2*DW+$clog2(K*K)-1:0] out_data,
   input logic                        out_last,
   input logic                        done,
   input logic                        cfg_err
);
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

   a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !pix_ready);

   a_r11_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(coef_ready && pix_ready));

   a_r1_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !(out_valid || coef_ready || pix_ready));

   a_r1_err_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_err) |-> done);

   a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !out_valid && !coef_ready && !pix_ready);

   a_r7_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);
endmodule

bind dwxc_engine dwxc_engine_chk #(
   .DW(DW), .K(K), .MAX_W(MAX_W), .DIM_W(DIM_W), .SW(SW), .CHW(CHW)
) u_chk (.*);

// File: tb/dwxc_engine_bench.sv
module dwxc_engine_bench;
   localparam int DW = 8, K = 3, MAX_W = 16, DIM_W = 8, SW = 4, CHW = 4;
   localparam int ACC_W = 20;
   localparam int NV = 5;
   localparam int MAXC = 100000;
   // columns: height, width, stride, channels, mode (1 = all values -128)
   localparam int TBL [NV][5] = '{
      '{5, 5, 1, 2, 0},
      '{7, 8, 2, 2, 0},
      '{3, 16, 3, 1, 0},
      '{6, 4, 5, 3, 0},
      '{3, 3, 1, 1, 1}
   };

   logic clk = 0, rst_n = 0, start = 0;
   logic [DIM_W-1:0] cfg_height = 0, cfg_width = 0;
   logic [SW-1:0] cfg_stride = 0;
   logic [CHW-1:0] cfg_chans = 0;
   logic coef_valid = 0, pix_valid = 0, out_ready = 0;
   logic [DW-1:0] coef_data = 0, pix_data = 0;
   logic coef_ready, pix_ready, out_valid, out_last, done, cfg_err;
   logic [ACC_W-1:0] out_data;

   int checks = 0, errors = 0, cyc = 0;
   int exp_v [512];
   bit exp_l [512];

   always #4 clk = ~clk;

   dwxc_engine #(.DW(DW), .K(K), .MAX_W(MAX_W), .DIM_W(DIM_W), .SW(SW), .CHW(CHW)) u_dwxc_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_height(cfg_height), .cfg_width(cfg_width),
      .cfg_stride(cfg_stride), .cfg_chans(cfg_chans), .coef_valid(coef_valid),
      .coef_ready(coef_ready), .coef_data(coef_data), .pix_valid(pix_valid),
      .pix_ready(pix_ready), .pix_data(pix_data), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
      .done(done), .cfg_err(cfg_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > MAXC) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, MAXC);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   function automatic int coef_val(int v, int ch, int idx);
      if (TBL[v][4] == 1) return -128;
      return ((ch * 37 + idx * 53 + v * 11 + 5) % 256) - 128;
   endfunction

   function automatic int pix_val(int v, int ch, int r, int c);
      if (TBL[v][4] == 1) return -128;
      return ((ch * 71 + r * 29 + c * 13 + v * 3 + 7) % 256) - 128;
   endfunction

   task automatic send_coef(input int val);
      @(negedge clk);
      pix_valid = 0;
      coef_valid = 1;
      coef_data = DW'(val);
      #1;
      chk(!pix_ready, "R2 pixel ready during kernel load", int'(pix_ready), 0);
      while (!coef_ready) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic send_pix(input int val);
      @(negedge clk);
      coef_valid = 0;
      pix_valid = 1;
      pix_data = DW'(val);
      #1;
      while (!pix_ready) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic drive_job(input int v);
      int h, w, nch;
      h = TBL[v][0];
      w = TBL[v][1];
      nch = TBL[v][3];
      for (int ch = 0; ch < nch; ch++) begin
         for (int i = 0; i < K * K; i++) send_coef(coef_val(v, ch, i));
         for (int r = 0; r < h; r++)
            for (int c = 0; c < w; c++) send_pix(pix_val(v, ch, r, c));
      end
      @(negedge clk);
      pix_valid = 0;
      coef_valid = 0;
   endtask

   task automatic collect_job(input int v);
      int h, w, s, nch, orows, ocols, total, n, seen, k;
      h = TBL[v][0]; w = TBL[v][1]; s = TBL[v][2]; nch = TBL[v][3];
      orows = (h - K) / s + 1;
      ocols = (w - K) / s + 1;
      total = 0;
      for (int ch = 0; ch < nch; ch++)
         for (int i = 0; i < orows; i++)
            for (int j = 0; j < ocols; j++) begin
               int acc;
               acc = 0;
               for (int r = 0; r < K; r++)
                  for (int c = 0; c < K; c++)
                     acc += coef_val(v, ch, r * K + c) * pix_val(v, ch, i * s + r, j * s + c);
               exp_v[total] = acc;
               exp_l[total] = (i == orows - 1) && (j == ocols - 1);
               total++;
            end
      n = 0;
      k = 0;
      while (n < total) begin
         @(negedge clk);
         k++;
         out_ready = (v == 0 || v == 4) ? 1'b1 : (((k * 3 + v) % 4) != 0);
         #1;
         if (out_valid && out_ready) begin
            chk(out_data == ACC_W'(exp_v[n]), "R3 R4 R6 result value",
                int'($signed(out_data)), exp_v[n]);
            chk(out_last == exp_l[n], "R7 last flag", int'(out_last), int'(exp_l[n]));
            n++;
         end
      end
      out_ready = 1;
      seen = 0;
      for (int t = 0; t < 60 && seen == 0; t++) begin
         @(negedge clk);
         #1;
         if (out_valid) begin
            chk(0, "R5 extra result", 1, 0);
         end
         if (done) seen = 1;
      end
      chk(seen == 1, "R8 done after last result", seen, 1);
      chk(cfg_err == 0, "R1 no error on legal job", int'(cfg_err), 0);
      @(negedge clk);
      #1;
      chk(done == 0, "R8 done is one cycle", int'(done), 0);
   endtask

   task automatic bad_cfg(input int h, input int w, input int s, input int nch);
      @(negedge clk);
      cfg_height = DIM_W'(h); cfg_width = DIM_W'(w);
      cfg_stride = SW'(s); cfg_chans = CHW'(nch);
      start = 1;
      @(negedge clk);
      start = 0;
      #1;
      chk(done == 1, "R1 done after illegal start", int'(done), 1);
      chk(cfg_err == 1, "R1 error flag", int'(cfg_err), 1);
      chk(!out_valid && !coef_ready && !pix_ready, "R1 no traffic",
          int'({out_valid, coef_ready, pix_ready}), 0);
      @(negedge clk);
      #1;
      chk(done == 0 && cfg_err == 1, "R1 done pulse and held error",
          int'({done, cfg_err}), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R10 reset state
      chk(!out_valid && !coef_ready && !pix_ready && !done && !cfg_err, "R10 reset outputs",
          int'({out_valid, coef_ready, pix_ready, done, cfg_err}), 0);
      @(negedge clk);
      rst_n = 1;
      #1;
      chk(!out_valid && !coef_ready && !pix_ready && !done, "R10 idle after reset",
          int'({out_valid, coef_ready, pix_ready, done}), 0);

      bad_cfg(5, 5, 0, 1);          // stride 0
      bad_cfg(2, 5, 1, 1);          // height below K
      bad_cfg(5, 2, 1, 1);          // width below K
      bad_cfg(5, MAX_W + 1, 1, 1);  // width beyond line buffer
      bad_cfg(5, 5, 1, 0);          // no channels

      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         cfg_height = DIM_W'(TBL[v][0]); cfg_width = DIM_W'(TBL[v][1]);
         cfg_stride = SW'(TBL[v][2]);    cfg_chans = CHW'(TBL[v][3]);
         start = 1;
         @(negedge clk);
         start = 0;
         #1;
         chk(coef_ready && !pix_ready, "R2 R11 kernel load first",
             int'({coef_ready, pix_ready}), 2);
         fork
            drive_job(v);
            collect_job(v);
         join
      end

      // R6 explicit extreme-value boundary: 9 * (-128)*(-128)
      chk(exp_v[0] == 147456, "R6 extreme sum reference", exp_v[0], 147456);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule